// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands a command to a power-management microcontroller and later collects the outcome. The host uses a plain 32-bit register bus with word-aligned byte offsets. Through it the host reaches a command word, a status word, two pointer words and two 16-byte data areas. One data area carries arguments out to the controller and the other carries results back. A write to the command word rings the doorbell. The block then shows the responder a one-cycle request strobe together with the decoded command fields, the pointers and the outbound words.

The responder may deposit result words while the transaction is open. It closes the transaction with a completion strobe that carries an error flag and an 8-bit error code. Completion drops the busy bit. It raises the host interrupt only when the command asked for one, and the host clears that interrupt by writing 1 to it. Error codes 0 to 7 stand for: success, unsupported, not serviced, cannot service, invalid, failed, security refusal and unsigned image. The block passes the code through without interpreting it.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every mapped register reads zero, busy is clear and `irq` is low.
- R2: A host write to offset 0x00 while idle stores the word, sets busy (status bit 0) from the next cycle and pulses `req_valid` for exactly one cycle. The decoded fields are: code = bits 7:0, interrupt request = bit 8, sub-command = bits 15:12, byte length = bits 20:16.
- R3: A write to offset 0x00 while busy is set is ignored. The stored command word does not change and no request strobe is produced.
- R4: `rsp_done` while busy clears busy. The error flag goes to status bit 1, and when that flag is set the error code goes to status bits 23:16. A completion without error leaves bits 23:16 at zero.
- R5: A completion sets status bit 2 and drives `irq` high only if bit 8 of the triggering command word was 1.
- R6: Writing the status word (offset 0x04) with bit 2 set clears the interrupt flag. Writing it with bit 2 clear leaves the flag unchanged.
- R7: An accepted command clears any earlier error flag and error code.
- R8: `rsp_wr` stores `rsp_wdata` into inbound word `rsp_widx` only while busy. The inbound words read back at 0x90, 0x94, 0x98 and 0x9C, and host writes to these offsets are ignored.
- R9: The source pointer (0x08), destination pointer (0x0C) and outbound words (0x80 to 0x8C) are host read/write. They appear on `req_sptr`, `req_dptr` and `req_data`, with word 0 in the low 32 bits.
- R10: Reads of unmapped or misaligned offsets return zero, and writes to them change no register.
- R11: `rsp_done` while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write (1) or read (0) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Host completion interrupt |
| req_valid | output | 1 | One-cycle doorbell to the responder |
| req_code | output | 8 | Command code |
| req_sub | output | 4 | Sub-command |
| req_len | output | LEN_W | Input length in bytes |
| req_irq_en | output | 1 | Completion interrupt requested |
| req_sptr | output | 32 | Source pointer |
| req_dptr | output | 32 | Destination pointer |
| req_data | output | 32*N_WORDS | Outbound words |
| rsp_wr | input | 1 | Inbound word write strobe |
| rsp_widx | input | $clog2(N_WORDS) | Inbound word index |
| rsp_wdata | input | 32 | Inbound word data |
| rsp_done | input | 1 | Completion strobe |
| rsp_err | input | 1 | Completion carries an error |
| rsp_code | input | 8 | Error code |

## Verification
The assertions assume that the host and the responder follow the handshake. `rsp_done` is a single-cycle pulse, and the responder drives its strobes for exactly one cycle per event. The stimulus pulses every bus access and every responder strobe for exactly one cycle. Bus accesses and responder strobes never share a cycle. The bench also deliberately sends a doorbell while busy, a completion while idle and inbound writes while idle, to exercise the paths where the block ignores its inputs.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 4,
  parameter int LEN_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    irq,
  output logic                    req_valid,
  output logic [7:0]              req_code,
  output logic [3:0]              req_sub,
  output logic [LEN_W-1:0]        req_len,
  output logic                    req_irq_en,
  output logic [31:0]             req_sptr,
  output logic [31:0]             req_dptr,
  output logic [32*N_WORDS-1:0]   req_data,
  input  logic                    rsp_wr,
  input  logic [$clog2(N_WORDS)-1:0] rsp_widx,
  input  logic [31:0]             rsp_wdata,
  input  logic                    rsp_done,
  input  logic                    rsp_err,
  input  logic [7:0]              rsp_code
);
  localparam int IDX_W = $clog2(N_WORDS);
  localparam int BSH   = IDX_W + 2;
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_SPTR = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_OBUF = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] A_IBUF = ADDR_W'('h90);

  logic [31:0] cmd_q, sptr_q, dptr_q;
  logic [31:0] obuf [N_WORDS];
  logic [31:0] ibuf [N_WORDS];
  logic        busy_q, err_q, irqf_q, req_q;
  logic [7:0]  code_q;

  wire aligned = bus_addr[1:0] == 2'b00;
  wire hit_cmd  = aligned && bus_addr == A_CMD;
  wire hit_sts  = aligned && bus_addr == A_STS;
  wire hit_sptr = aligned && bus_addr == A_SPTR;
  wire hit_dptr = aligned && bus_addr == A_DPTR;
  wire hit_obuf = aligned && (bus_addr >> BSH) == (A_OBUF >> BSH);
  wire hit_ibuf = aligned && (bus_addr >> BSH) == (A_IBUF >> BSH);
  wire [IDX_W-1:0] widx = bus_addr[BSH-1:2];
  wire wr_en   = bus_sel && bus_wr;
  wire cmd_go  = wr_en && hit_cmd && !busy_q;
  wire fin     = rsp_done && busy_q;
  wire [31:0] sts_word = {8'h00, code_q, 13'h0, irqf_q, err_q, busy_q};

  always_comb begin
    bus_rdata = '0;
    if (hit_cmd)       bus_rdata = cmd_q;
    else if (hit_sts)  bus_rdata = sts_word;
    else if (hit_sptr) bus_rdata = sptr_q;
    else if (hit_dptr) bus_rdata = dptr_q;
    else if (hit_obuf) bus_rdata = obuf[widx];
    else if (hit_ibuf) bus_rdata = ibuf[widx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; sptr_q <= '0; dptr_q <= '0;
      busy_q <= 1'b0; err_q <= 1'b0; irqf_q <= 1'b0; req_q <= 1'b0;
      code_q <= '0;
      for (int i = 0; i < N_WORDS; i++) begin
        obuf[i] <= '0;
        ibuf[i] <= '0;
      end
    end else begin
      req_q <= cmd_go;
      if (wr_en && hit_sptr) sptr_q <= bus_wdata;
      if (wr_en && hit_dptr) dptr_q <= bus_wdata;
      if (wr_en && hit_obuf) obuf[widx] <= bus_wdata;
      if (rsp_wr && busy_q) ibuf[rsp_widx] <= rsp_wdata;
      if (wr_en && hit_sts && bus_wdata[2]) irqf_q <= 1'b0;
      if (cmd_go) begin
        cmd_q  <= bus_wdata;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (fin) begin
        busy_q <= 1'b0;
        err_q  <= rsp_err;
        code_q <= rsp_err ? rsp_code : 8'h00;
        if (cmd_q[8]) irqf_q <= 1'b1;
      end
    end
  end

  assign irq        = irqf_q;
  assign req_valid  = req_q;
  assign req_code   = cmd_q[7:0];
  assign req_irq_en = cmd_q[8];
  assign req_sub    = cmd_q[15:12];
  assign req_len    = cmd_q[16 +: LEN_W];
  assign req_sptr   = sptr_q;
  assign req_dptr   = dptr_q;
  for (genvar g = 0; g < N_WORDS; g++) begin : g_pack
    assign req_data[32*g +: 32] = obuf[g];
  end

  a_r2_busy_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && hit_cmd && !busy_q) |=> (busy_q && req_valid));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  a_r3_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && hit_cmd && busy_q) |=> (!req_valid && $stable(cmd_q)));
  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && busy_q && !(bus_sel && bus_wr)) |=> !busy_q);
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(rsp_done) && $past(cmd_q[8])));
  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !busy_q && !(bus_sel && bus_wr)) |=> (!busy_q && $stable(err_q) && $stable(code_q)));
endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, req_valid, req_irq_en;
  logic [7:0] req_code;
  logic [3:0] req_sub;
  logic [4:0] req_len;
  logic [31:0] req_sptr, req_dptr;
  logic [127:0] req_data;
  logic rsp_wr = 0, rsp_done = 0, rsp_err = 0;
  logic [1:0] rsp_widx = 0;
  logic [31:0] rsp_wdata = 0;
  logic [7:0] rsp_code = 0;

  always #5 clk = ~clk;

  ipc_mailbox u_ipc_mailbox (.*);

  typedef struct packed {
    logic [7:0] code; logic [3:0] sub; logic [4:0] len; logic ien;
    logic [31:0] sp; logic [31:0] dp; logic [127:0] data;
  } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  logic [31:0] m_sp = 0, m_dp = 0;
  logic [127:0] m_data = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && req_valid) begin
    exp_t got;
    tests++;
    got = '{req_code, req_sub, req_len, req_irq_en, req_sptr, req_dptr, req_data};
    if (q.size() == 0) begin
      fails++;
      $display("FAIL R3 unexpected request actual=%h expected=none", got[31:0]);
    end else begin
      exp_t e;
      e = q.pop_front();
      if (got !== e) begin
        fails++;
        $display("FAIL R2 request fields actual=%h expected=%h", got, e);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic send(logic [31:0] w, bit accept);
    if (accept) q.push_back('{w[7:0], w[15:12], w[20:16], w[8], m_sp, m_dp, m_data});
    wr(8'h00, w);
  endtask

  task automatic done(logic e, logic [7:0] c);
    @(negedge clk); rsp_done = 1; rsp_err = e; rsp_code = c;
    @(negedge clk); rsp_done = 0; rsp_err = 0;
  endtask

  task automatic inb(logic [1:0] i, logic [31:0] d);
    @(negedge clk); rsp_wr = 1; rsp_widx = i; rsp_wdata = d;
    @(negedge clk); rsp_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h04, v); chk("R1 status", v, 0);
    rd(8'h00, v); chk("R1 cmd", v, 0);
    rd(8'h90, v); chk("R1 inbound", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    // R9 pointers and outbound buffer
    m_sp = 32'h0000_1234; m_dp = 32'h0000_5678;
    wr(8'h08, m_sp); wr(8'h0C, m_dp);
    for (int i = 0; i < 4; i++) begin
      wr(8'h80 + 8'(4*i), 32'hA0A0_0000 + i);
      m_data[32*i +: 32] = 32'hA0A0_0000 + i;
    end
    rd(8'h08, v); chk("R9 sptr", v, m_sp);
    rd(8'h0C, v); chk("R9 dptr", v, m_dp);
    rd(8'h88, v); chk("R9 outbound word2", v, 32'hA0A0_0002);
    // R2 doorbell with interrupt request
    send(32'h0008_3142, 1);
    rd(8'h04, v); chk("R2 busy", v, 32'h1);
    // R3 doorbell while busy
    send(32'h0000_0055, 0);
    rd(8'h00, v); chk("R3 cmd kept", v, 32'h0008_3142);
    // R8 inbound while busy
    for (int i = 0; i < 4; i++) inb(2'(i), 32'hB0B0_0000 + i);
    done(0, 8'h00);
    rd(8'h04, v); chk("R5 irq flag set", v, 32'h4);
    chk("R5 irq pin", {31'b0, irq}, 1);
    rd(8'h9C, v); chk("R8 inbound word3", v, 32'hB0B0_0003);
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, v); chk("R8 host write ignored", v, 32'hB0B0_0000);
    // R6 write-1-to-clear
    wr(8'h04, 32'h0000_0003);
    rd(8'h04, v); chk("R6 bit2 zero keeps", v, 32'h4);
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, v); chk("R6 cleared", v, 32'h0);
    chk("R6 irq pin low", {31'b0, irq}, 0);
    // R8 inbound while idle
    inb(2'd0, 32'hDEAD_BEEF);
    rd(8'h90, v); chk("R8 idle write ignored", v, 32'hB0B0_0000);
    // R4 error completion, no interrupt request
    send(32'h0000_0007, 1);
    done(1, 8'h05);
    rd(8'h04, v); chk("R4 error status", v, 32'h0005_0002);
    chk("R5 no irq without bit8", {31'b0, irq}, 0);
    // R7 new command clears error
    send(32'h0010_2010, 1);
    rd(8'h04, v); chk("R7 error cleared", v, 32'h1);
    done(0, 8'h99);
    rd(8'h04, v); chk("R4 clean completion", v, 32'h0);
    // R10 unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R10 unmapped read", v, 0);
    wr(8'h09, 32'h1111_1111);
    rd(8'h08, v); chk("R10 misaligned write", v, m_sp);
    rd(8'h09, v); chk("R10 misaligned read", v, 0);
    // R11 completion while idle
    done(1, 8'h07);
    rd(8'h04, v); chk("R11 idle done", v, 0);
    repeat (3) @(negedge clk);
    chk("R2 all requests seen", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule